// File: doc/BRIEF.md
# Periodic Serial ADC Sample Reader

This block is the master side of a three-wire link to a low-power converter with serial output. It drives an active-low chip select, which also acts as frame sync and starts a conversion when it falls. It drives a serial clock divided down from the system clock and reads the serial data line. An internal sample timer requests a conversion every N serial-clock periods. Each request is held back until the serial clock has been high, then low, then high again. Because the timer counts whole serial-clock periods, consecutive frames start exactly the same number of system clocks apart.

The word length follows a two-bit mode that matches the converter resolution. The received word is right-justified to the resolution and its leading zeros are removed. In the 10-bit case the two trailing bits, sent after the converter has released its data line, are discarded. Every result leaves on a data bus together with a one-cycle valid strobe. If a timer request arrives while a frame is still running, the request is dropped and a sticky overrun flag is raised. Configuration is taken only while the run input is low. Dropping run is a synchronous return to idle.

Top module: `adc_sample_reader`

## Requirements
- R1: While running, `sclk_o` toggles every `div_i`+1 system clocks, so one serial-clock period lasts 2×(`div_i`+1) system clocks.
- R2: `cs_no` falls only on the same system-clock edge where `sclk_o` rises. A timer request waits for the serial clock to go low and then high again before the frame starts.
- R3: Consecutive falling edges of `cs_no` are exactly `period_i`×2×(`div_i`+1) system clocks apart, provided `period_i` is at least the word length plus 3.
- R4: `cs_no` stays low for exactly W serial-clock periods. W is 16 in modes 0, 2 and 3 and 12 in mode 1. Serial data is sampled on the W falling edges of `sclk_o` in that window, most significant bit first.
- R5: In mode 0 (12-bit converter) `data_o` holds the low 12 bits of the 16-bit word. In mode 1 (8-bit converter) it holds the low 8 bits of the 12-bit word, zero-extended.
- R6: In mode 2 (10-bit converter) `data_o` is bits 11..2 of the 16-bit word, zero-extended. The two last-received bits have no effect on the result.
- R7: `valid_o` is high for exactly one system clock per frame, while `cs_no` is still low, and `data_o` holds that frame's result in that cycle.
- R8: A timer request that arrives while a frame is in progress sets `overrun_o`, which stays high while `run_i` stays high, and the request starts no frame. Without such a request `overrun_o` stays low.
- R9: Changes to `div_i`, `period_i` and `mode_i` while `run_i` is high have no effect. The values present in the last cycle with `run_i` low are used.
- R10: One clock edge after `run_i` is sampled low, `cs_no` and `sclk_o` are high, `valid_o` is low and `overrun_o` is cleared.
- R11: Asserting `rst_ni` low at once forces `cs_no` and `sclk_o` high and `valid_o`, `overrun_o` and `data_o` to zero.
- R12: Mode 3 behaves exactly as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | High: run the timer and frames. Low: idle and load the configuration |
| div_i | input | DIV_W | Serial-clock divider value |
| period_i | input | PER_W | Sample period in serial-clock periods |
| mode_i | input | 2 | Converter resolution mode: 0 = 12-bit, 1 = 8-bit, 2 = 10-bit, 3 = same as 0 |
| sdata_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Active-low chip select / frame sync |
| data_o | output | 12 | Right-justified sample |
| valid_o | output | 1 | One-cycle strobe for a new sample |
| overrun_o | output | 1 | Sticky flag for a dropped timer request |

## Verification
The bench keeps the default widths (DIV_W = 8, PER_W = 12) and programs divider values from 0 to 6. This covers the case where the serial clock toggles on every system clock, as well as several multi-cycle half periods. All four modes are run, and periods are chosen both above and below the word length plus 3, so that both equidistant frames and overrun-dropped requests occur. A behavioural converter model drives ones into the trailing bits of the 10-bit mode, so any leakage of those bits shows up in the result.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int RES_W = 12;
  localparam int SR_W  = 16;
  localparam int CNT_W = $clog2(SR_W) + 1;

  typedef enum logic [1:0] {
    MODE_R12 = 2'd0,
    MODE_R8  = 2'd1,
    MODE_R10 = 2'd2,
    MODE_ALT = 2'd3
  } res_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM_LOW,
    ST_ARM_HIGH,
    ST_SHIFT,
    ST_HOLD,
    ST_GAP
  } frame_st_e;

  function automatic logic [CNT_W-1:0] word_bits(input res_mode_e m);
    return (m == MODE_R8) ? CNT_W'(12) : CNT_W'(SR_W);
  endfunction

  function automatic logic [RES_W-1:0] extract(input res_mode_e m, input logic [SR_W-1:0] w);
    case (m)
      MODE_R8:  return {4'b0, w[7:0]};
      MODE_R10: return {2'b0, w[11:2]};
      default:  return w[RES_W-1:0];
    endcase
  endfunction
endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             hit;

  assign hit    = run_i && (cnt_q == div_i);
  assign rise_o = hit && !sclk_q;
  assign fall_o = hit && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (hit) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int PER_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             rise_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  logic [PER_W-1:0] cnt_q;

  // counts whole serial-clock periods, so ticks always sit on a rising edge
  assign tick_o = rise_i && (cnt_q == period_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else if (rise_i)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_rd_frame.sv
module adc_rd_frame
  import adc_rd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             tick_i,
  input  res_mode_e        mode_i,
  input  logic             sdata_i,
  output logic             cs_no,
  output logic [RES_W-1:0] data_o,
  output logic             valid_o,
  output logic             overrun_o
);
  frame_st_e        st_q;
  logic [SR_W-1:0]  sr_q;
  logic [SR_W-1:0]  sr_next;
  logic [CNT_W-1:0] bit_q;
  logic             last_bit;

  assign sr_next  = {sr_q[SR_W-2:0], sdata_i};
  assign last_bit = (bit_q == word_bits(mode_i) - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sr_q      <= '0;
      bit_q     <= '0;
      cs_no     <= 1'b1;
      data_o    <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else if (!run_i) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      cs_no     <= 1'b1;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i && st_q != ST_IDLE) overrun_o <= 1'b1;
      case (st_q)
        ST_IDLE:     if (tick_i) st_q <= ST_ARM_LOW;
        ST_ARM_LOW:  if (fall_i) st_q <= ST_ARM_HIGH;
        ST_ARM_HIGH: if (rise_i) begin
          cs_no <= 1'b0;
          bit_q <= '0;
          st_q  <= ST_SHIFT;
        end
        ST_SHIFT:    if (fall_i) begin
          sr_q  <= sr_next;
          bit_q <= bit_q + 1'b1;
          if (last_bit) begin
            data_o  <= extract(mode_i, sr_next);
            valid_o <= 1'b1;
            st_q    <= ST_HOLD;
          end
        end
        ST_HOLD:     if (rise_i) begin
          cs_no <= 1'b1;
          st_q  <= ST_GAP;
        end
        ST_GAP:      if (rise_i) st_q <= ST_IDLE;
        default:     st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_sample_reader.sv
module adc_sample_reader
  import adc_rd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PER_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [1:0]       mode_i,
  input  logic             sdata_i,
  output logic             sclk_o,
  output logic             cs_no,
  output logic [11:0]      data_o,
  output logic             valid_o,
  output logic             overrun_o
);
  logic [DIV_W-1:0] div_q;
  logic [PER_W-1:0] per_q;
  res_mode_e        mode_q;
  logic             rise, fall, tick;

  // configuration is frozen for the whole run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      per_q  <= '0;
      mode_q <= MODE_R12;
    end else if (!run_i) begin
      div_q  <= div_i;
      per_q  <= period_i;
      mode_q <= res_mode_e'(mode_i);
    end
  end

  adc_rd_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .div_i  (div_q),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  adc_rd_timer #(.PER_W(PER_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .rise_i   (rise),
    .period_i (per_q),
    .tick_o   (tick)
  );

  adc_rd_frame i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .tick_i    (tick),
    .mode_i    (mode_q),
    .sdata_i   (sdata_i),
    .cs_no     (cs_no),
    .data_o    (data_o),
    .valid_o   (valid_o),
    .overrun_o (overrun_o)
  );
endmodule

// File: rtl/adc_sample_reader_chk.sv
module adc_sample_reader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic sclk_o,
  input logic cs_no,
  input logic valid_o,
  input logic overrun_o
);
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R7
  AST_VALID_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !cs_no); // R7
  AST_CS_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $rose(sclk_o)); // R2
  AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cs_no && sclk_o && !valid_o && !overrun_o)); // R10
  AST_OVERRUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && overrun_o) |=> overrun_o); // R8
endmodule

bind adc_sample_reader adc_sample_reader_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_i),
  .sclk_o    (sclk_o),
  .cs_no     (cs_no),
  .valid_o   (valid_o),
  .overrun_o (overrun_o)
);

// File: tb/test_adc_sample_reader.sv
module test_adc_sample_reader;
  localparam int DIV_W = 8;
  localparam int PER_W = 12;

  typedef struct packed {
    logic [7:0]  dv;
    logic [11:0] pr;
    logic [1:0]  md;
    logic [15:0] wd;
    logic [11:0] ex;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'd0, 12'd20, 2'd0, 16'h0A5C, 12'hA5C},
    '{8'd1, 12'd16, 2'd1, 16'h00C3, 12'h0C3},
    '{8'd3, 12'd19, 2'd2, 16'h0ADC, 12'h2B7},
    '{8'd2, 12'd25, 2'd3, 16'h0FFF, 12'hFFF},
    '{8'd0, 12'd19, 2'd0, 16'h0001, 12'h001},
    '{8'd5, 12'd30, 2'd1, 16'h0080, 12'h080}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic             sdata = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic [PER_W-1:0] per = 12'd20;
  logic [1:0]       mode = 2'd0;
  logic             sclk, cs_n, valid, ovr;
  logic [11:0]      data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_sample_reader #(.DIV_W(DIV_W), .PER_W(PER_W)) i_adc_sample_reader (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .run_i     (run),
    .div_i     (div),
    .period_i  (per),
    .mode_i    (mode),
    .sdata_i   (sdata),
    .sclk_o    (sclk),
    .cs_no     (cs_n),
    .data_o    (data),
    .valid_o   (valid),
    .overrun_o (ovr)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter model: changes data after each serial-clock rise, MSB first, ones after release
  logic [15:0] adc_word = '0;
  int adc_w = 16;
  int adc_vb = 16;
  int bidx = 0;
  logic m_cs = 1'b1;
  logic m_sc = 1'b1;
  always @(negedge clk) begin
    if (cs_n || m_cs) bidx = 0;
    else if (sclk && !m_sc) bidx = bidx + 1;
    sdata <= (bidx < adc_vb) ? adc_word[adc_w-1-bidx] : 1'b1;
    m_cs = cs_n;
    m_sc = sclk;
  end

  task automatic run_vec(input vec_t v, input string rq);
    int w, vb, hp, frames, valids, toggles, last_tog, last_fall;
    logic pcs, psc, pv;
    w = (v.md == 2'd1) ? 12 : 16;
    vb = (v.md == 2'd2) ? 14 : w;
    hp = int'(v.dv) + 1;
    frames = 0; valids = 0; toggles = 0; last_tog = 0; last_fall = -1;
    pcs = 1'b1; psc = 1'b1; pv = 1'b0;
    run = 1'b0;
    div = v.dv; per = v.pr; mode = v.md;
    adc_word = v.wd; adc_w = w; adc_vb = vb;
    repeat (3) @(negedge clk);
    run = 1'b1;
    for (int t = 0; t < 20000 && frames < 3; t++) begin
      @(negedge clk);
      if (sclk !== psc) begin
        toggles++;
        if (toggles == 3) chk(cyc - last_tog == hp, "R1", "sclk half period", cyc - last_tog, hp);
        last_tog = cyc;
      end
      if (pcs && !cs_n) begin
        chk(!psc && sclk, "R2", "cs fall with sclk rise", int'(sclk), 1);
        if (last_fall >= 0)
          chk(cyc - last_fall == int'(v.pr) * 2 * hp, "R3", "frame spacing",
              cyc - last_fall, int'(v.pr) * 2 * hp);
        last_fall = cyc;
      end
      if (!pcs && cs_n)
        begin
          chk(cyc - last_fall == w * 2 * hp, "R4", "cs low length", cyc - last_fall, w * 2 * hp);
          frames++;
        end
      if (valid) begin
        valids++;
        chk(data == v.ex, rq, "sample value", int'(data), int'(v.ex));
        chk(!cs_n, "R7", "valid inside frame", int'(cs_n), 0);
        if (pv) chk(1'b0, "R7", "valid wider than one cycle", 2, 1);
      end
      pv = valid; pcs = cs_n; psc = sclk;
    end
    chk(valids == 3, "R7", "valid count", valids, 3);
    chk(!ovr, "R8", "no overrun at legal period", int'(ovr), 0);
    run = 1'b0;
    @(negedge clk);
    chk(cs_n && sclk, "R10", "idle after run low", int'({cs_n, sclk}), 3);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hp_seen, low_len, fall_t, t0;
    logic ps, pc;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs_n === 1'b1 && sclk === 1'b1, "R11", "cs/sclk in reset", int'({cs_n, sclk}), 3);
    chk(valid === 1'b0 && ovr === 1'b0 && data === 12'd0, "R11", "outputs in reset", int'(data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++)
      run_vec(VECS[i], (VECS[i].md == 2'd2) ? "R6" : (VECS[i].md == 2'd3) ? "R12" : "R5");

    // R8 period too short: overrun raised, later cleared by run low (R10)
    div = 8'd0; per = 12'd14; mode = 2'd0; adc_word = 16'h0123; adc_w = 16; adc_vb = 16;
    repeat (2) @(negedge clk);
    run = 1'b1;
    repeat (120) @(negedge clk);
    chk(ovr === 1'b1, "R8", "overrun on short period", int'(ovr), 1);
    repeat (40) @(negedge clk);
    chk(ovr === 1'b1, "R8", "overrun sticky", int'(ovr), 1);
    run = 1'b0;
    @(negedge clk);
    chk(ovr === 1'b0 && cs_n === 1'b1, "R10", "overrun cleared by run low", int'(ovr), 0);

    // R9 configuration changes during run are ignored
    div = 8'd1; per = 12'd20; mode = 2'd0;
    repeat (2) @(negedge clk);
    run = 1'b1;
    repeat (10) @(negedge clk);
    div = 8'd6; per = 12'd3; mode = 2'd1;
    ps = sclk; hp_seen = 0; t0 = -1;
    for (int t = 0; t < 200 && hp_seen == 0; t++) begin
      @(negedge clk);
      if (sclk !== ps) begin
        if (t0 >= 0) hp_seen = cyc - t0;
        t0 = cyc;
      end
      ps = sclk;
    end
    chk(hp_seen == 2, "R9", "half period after div change", hp_seen, 2);
    pc = cs_n; low_len = 0; fall_t = -1;
    for (int t = 0; t < 2000 && low_len == 0; t++) begin
      @(negedge clk);
      if (pc && !cs_n) fall_t = cyc;
      if (!pc && cs_n && fall_t >= 0) low_len = cyc - fall_t;
      pc = cs_n;
    end
    chk(low_len == 64, "R9", "word length after mode change", low_len, 64);
    chk(ovr === 1'b0, "R9", "period change ignored", int'(ovr), 0);

    // R11 asynchronous reset mid-run
    @(negedge clk);
    while (cs_n) @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    chk(cs_n === 1'b1 && sclk === 1'b1 && valid === 1'b0, "R11", "async reset mid-frame",
        int'({cs_n, sclk}), 3);
    run = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule